// File: doc/BRIEF.md
# Armed-on-write watchdog with bit-six timeout

The block is a watchdog that guards a processor against running away. A 7-bit down-counter advances on a slow tick. The tick comes from a chain of fixed binary divider stages fed by the oscillator clock, and by default it divides by 16384. The counter shares one 8-bit register with a sticky enable flag: the enable is bit 7 and the counter is bits 6:0. The counter always runs, whether the watchdog is armed or not. Once the watchdog is armed, the moment counter bit 6 drops from 1 to 0 counts as a timeout. Software keeps the system alive by rewriting the register with a value between 0xC0 and 0xFF. The low six bits of that value set how many ticks remain before the timeout.

There are three more sources of reset. A write that leaves the watchdog armed but carries a 0 in bit 6 gives an immediate software reset. A HALT request while armed gives a reset instead of a halt. At power-up a hardware configuration input decides whether the watchdog starts armed. Every reset source produces one active-low pulse of a fixed, parameterized number of oscillator cycles. While that pulse lasts, the block holds itself in its own reset values.

The control logic is a two-state machine. In `WD_RUN` the counter and prescaler run and writes are accepted. In `WD_PULSE` the reset output is driven low and the registers are held. The transition run→pulse is taken on a fire event: a timeout, a software reset or a HALT while armed. The transition pulse→run is taken when the pulse counter reaches its last cycle.

Top module: `wdog_guard`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `rd_data` equals {`hw_en_cfg`, 7'h7F} and `rst_out_n` is 1.
- R2: In `WD_RUN` the counter decrements by one (wrapping 0x00 to 0x7F) once every 2^(STG0_LOG2+STG1_LOG2+STG2_LOG2) cycles, including while the enable bit (bit 7) is 0. With the enable clear, no reset is produced.
- R3: With the enable set, a tick that takes the counter from 0x40 to 0x3F causes `rst_out_n` to go low on the next cycle.
- R4: Every fire event drives `rst_out_n` low for exactly PULSE_CYC consecutive cycles. During the pulse `rd_data` reads {`hw_en_cfg`, 7'h7F}, and writes and HALT are ignored.
- R5: A write with bit 7 = 1 sets the enable. The write strobe is `wr_stb`, the value is `wr_data`, and the result can be read on `rd_data`.
- R6: A write always loads bits 6:0 into the counter. If a tick falls in the same cycle, the write wins, so periodic writes of 0xC0–0xFF prevent any reset.
- R7: Once the enable is set, a write with bit 7 = 0 leaves it set. Only a reset pulse or `rst_n` restores it to `hw_en_cfg`.
- R8: A write whose bit 6 is 0, made while the enable is set or by a write whose bit 7 is 1, causes `rst_out_n` to go low on the next cycle.
- R9: `halt_req` high while the enable is set causes `rst_out_n` to go low on the next cycle. With the enable clear it has no effect.
- R10: `hw_en_cfg` = 1 makes the enable read 1 after `rst_n` and after every reset pulse.
- R11: Writes do not clear the prescaler. The first tick after a write comes at the prescaler's existing phase, not a full period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| hw_en_cfg | input | 1 | Hardware configuration: start armed |
| wr_stb | input | 1 | Register write strobe |
| wr_data | input | 8 | Write value: bit 7 enable, bits 6:0 counter |
| halt_req | input | 1 | HALT request from the core |
| rd_data | output | 8 | Register readback {enable, counter} |
| rst_out_n | output | 1 | Active-low reset pulse |

## Verification
The bench goes after four corner cases.

- **Timeout edge.** The bench hits the 0x40→0x3F transition itself. A design that fired at zero, or on 0x3F→0x3E, would hold `rst_out_n` high for the wrong number of cycles.
- **Sticky enable.** The bench writes bit 7 = 0 after arming. A non-sticky enable would then let the counter fall through 0x40 silently.
- **Write in a tick cycle.** The bench lands writes in the same cycle as a prescaler tick. A design that let the tick win would read back one below the written value.
- **Prescaler phase.** The bench refreshes in the middle of a prescaler period. A design that cleared the prescaler on writes would show the first tick too late.

Random writes, HALT requests and software resets are mixed into the run. The pulse length and the values restored after each pulse, with `hw_en_cfg` both 0 and 1, are compared cycle by cycle against a behavioural model.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [0:0] {
        WD_RUN   = 1'b0,
        WD_PULSE = 1'b1
    } wd_state_e;

    localparam int REG_W = 8;
    localparam int CNT_W = 7;

endpackage

// File: rtl/wdog_prediv.sv
module wdog_prediv #(
    parameter int LOG2 = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic carry
);
    logic [LOG2-1:0] acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clr) begin
            acc_q <= '0;
        end else if (step) begin
            acc_q <= acc_q + 1'b1;
        end
    end

    assign carry = step & (&acc_q);

endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int STG0_LOG2 = 2,
    parameter int STG1_LOG2 = 6,
    parameter int STG2_LOG2 = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic tick
);
    localparam int NSTG = 3;
    localparam int STG_LOG2 [NSTG] = '{STG0_LOG2, STG1_LOG2, STG2_LOG2};

    logic [NSTG:0] chain;

    assign chain[0] = run;

    for (genvar i = 0; i < NSTG; i++) begin : g_stage
        wdog_prediv #(.LOG2(STG_LOG2[i])) u_stage (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (clr),
            .step (chain[i]),
            .carry(chain[i+1])
        );
    end

    assign tick = chain[NSTG];

endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
    import wdog_pkg::*;
#(
    parameter int STG0_LOG2 = 2,
    parameter int STG1_LOG2 = 6,
    parameter int STG2_LOG2 = 6,
    parameter int PULSE_CYC = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_en_cfg,
    input  logic             wr_stb,
    input  logic [REG_W-1:0] wr_data,
    input  logic             halt_req,
    output logic [REG_W-1:0] rd_data,
    output logic             rst_out_n
);
    localparam int PC_W = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
    localparam logic [PC_W-1:0] PC_LAST = PC_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] CNT_INIT = '1;
    localparam logic [CNT_W-1:0] CNT_EDGE = CNT_W'(1 << (CNT_W - 1));

    wd_state_e        state_q, state_d;
    logic [PC_W-1:0]  pc_q;
    logic             en_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tick;
    logic             in_run, in_pulse;
    logic             en_eff, fire_tmo, fire_sw, fire_halt, fire;

    assign in_run   = (state_q == WD_RUN);
    assign in_pulse = (state_q == WD_PULSE);

    wdog_prescaler #(
        .STG0_LOG2(STG0_LOG2),
        .STG1_LOG2(STG1_LOG2),
        .STG2_LOG2(STG2_LOG2)
    ) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (in_run),
        .clr  (in_pulse),
        .tick (tick)
    );

    // Fire sources, evaluated in the run state only
    always_comb begin
        en_eff    = en_q | wr_data[REG_W-1];
        fire_sw   = wr_stb & en_eff & ~wr_data[CNT_W-1];
        fire_tmo  = ~wr_stb & tick & en_q & (cnt_q == CNT_EDGE);
        fire_halt = halt_req & en_q;
        fire      = in_run & (fire_sw | fire_tmo | fire_halt);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_RUN:   if (fire) state_d = WD_PULSE;
            WD_PULSE: if (pc_q == PC_LAST) state_d = WD_RUN;
            default:  state_d = WD_RUN;
        endcase
    end

    // State register and pulse length counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_RUN;
            pc_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == WD_PULSE) pc_q <= pc_q + 1'b1;
            else                     pc_q <= '0;
        end
    end

    // Control register: sticky enable plus free-running counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= hw_en_cfg;
            cnt_q <= CNT_INIT;
        end else if (in_pulse || fire) begin
            en_q  <= hw_en_cfg;
            cnt_q <= CNT_INIT;
        end else if (wr_stb) begin
            en_q  <= en_eff;
            cnt_q <= wr_data[CNT_W-1:0];
        end else if (tick) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Outputs
    always_comb begin
        rst_out_n = ~in_pulse;
        rd_data   = {en_q, cnt_q};
    end

endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hw_en_cfg,
    input logic       wr_stb,
    input logic [7:0] wr_data,
    input logic       halt_req,
    input logic [7:0] rd_data,
    input logic       rst_out_n
);
    a_r7_sticky_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_out_n && rd_data[7]) |=> (rd_data[7] || !rst_out_n));

    a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_out_n && !wr_stb) |=>
        (!rst_out_n || rd_data[6:0] == $past(rd_data[6:0]) ||
         rd_data[6:0] == $past(rd_data[6:0]) - 7'd1));

    a_r9_halt_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_out_n && rd_data[7] && halt_req) |=> !rst_out_n);

    a_r8_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_out_n && wr_stb && (wr_data[7] || rd_data[7]) && !wr_data[6]) |=> !rst_out_n);

    a_r4_held_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_out_n |-> (rd_data[6:0] == 7'h7F));

    a_r6_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_out_n && wr_stb && wr_data[6] && !halt_req) |=>
        (rd_data[6:0] == $past(wr_data[6:0])));

endmodule

bind wdog_guard wdog_guard_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hw_en_cfg(hw_en_cfg),
    .wr_stb   (wr_stb),
    .wr_data  (wr_data),
    .halt_req (halt_req),
    .rd_data  (rd_data),
    .rst_out_n(rst_out_n)
);

// File: tb/wdog_guard_tb.sv
module wdog_guard_tb;
    localparam int S0 = 1, S1 = 1, S2 = 1;
    localparam int PW = 5;
    localparam int PRE_N = 1 << (S0 + S1 + S2);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_en_cfg = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       halt_req = 1'b0;
    logic [7:0] rd_data;
    logic       rst_out_n;

    int vecs = 0, errs = 0, cyc = 0;
    bit done = 0;
    string phase = "R1";

    // Reference model state
    bit     m_en = 0, m_pulse = 0;
    int     m_cnt = 127, m_pre = 0, m_pc = 0;

    always #2.5 clk = ~clk;

    wdog_guard #(.STG0_LOG2(S0), .STG1_LOG2(S1), .STG2_LOG2(S2), .PULSE_CYC(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .hw_en_cfg(hw_en_cfg), .wr_stb(wr_stb),
        .wr_data(wr_data), .halt_req(halt_req), .rd_data(rd_data), .rst_out_n(rst_out_n)
    );

    function automatic void model_hold();
        m_en = hw_en_cfg; m_cnt = 127; m_pre = 0;
    endfunction

    always @(posedge clk) begin
        bit tick, fire, eff;
        cyc++;
        if (!rst_n) begin
            model_hold(); m_pulse = 0; m_pc = 0;
        end else if (m_pulse) begin
            model_hold();
            if (m_pc == PW - 1) begin m_pulse = 0; m_pc = 0; end
            else m_pc++;
        end else begin
            tick = (m_pre == PRE_N - 1);
            eff  = m_en || wr_data[7];
            fire = (wr_stb && eff && !wr_data[6]) ||
                   (!wr_stb && tick && m_en && m_cnt == 64) ||
                   (halt_req && m_en);
            if (fire) begin
                m_pulse = 1; m_pc = 0; model_hold();
            end else begin
                m_pre = (m_pre + 1) % PRE_N;
                if (wr_stb) begin m_en = eff; m_cnt = wr_data[6:0]; end
                else if (tick) m_cnt = (m_cnt + 127) % 128;
            end
        end
        #2;
        if (!done) begin
            vecs++;
            if (rd_data !== {m_en, 7'(m_cnt)} || rst_out_n !== !m_pulse) begin
                errs++;
                $display("FAIL %s cyc %0d: rd=%h rst_out_n=%b expected rd=%h rst_out_n=%b",
                         phase, cyc, rd_data, rst_out_n, {m_en, 7'(m_cnt)}, !m_pulse);
            end
        end
        if (cyc > 150000 && !done) begin
            errs++; done = 1;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] v);
        @(negedge clk); wr_stb = 1; wr_data = v;
        @(negedge clk); wr_stb = 0;
    endtask

    task automatic check(string req, bit ok, int act, int exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Counts low cycles of the next reset pulse
    task automatic pulse_len(string req);
        int n = 0, guard = 0;
        while (rst_out_n === 1'b1 && guard < 5000) begin @(negedge clk); guard++; end
        while (rst_out_n === 1'b0) begin n++; @(negedge clk); end
        check(req, n == PW, n, PW);
    endtask

    task automatic do_reset(bit hw);
        @(negedge clk); rst_n = 0; hw_en_cfg = hw;
        idle(3); rst_n = 1;
    endtask

    initial begin
        phase = "R1";
        do_reset(0);
        check("R1", rd_data == 8'h7F && rst_out_n, rd_data, 8'h7F);

        phase = "R2"; // disabled: counter wraps, no reset
        idle(140 * PRE_N);
        check("R2", rst_out_n === 1'b1, rst_out_n, 1);

        phase = "R5";
        wr(8'hC3);
        check("R5", rd_data[7] === 1'b1, rd_data[7], 1);

        phase = "R3"; // 0x43 -> fires at 0x40->0x3F
        pulse_len("R3");

        phase = "R6";
        wr(8'hC4);
        for (int k = 0; k < 40; k++) begin idle(2 * PRE_N + k % 5); wr(8'hC4); end
        check("R6", rst_out_n === 1'b1, rst_out_n, 1);

        phase = "R11"; // refresh mid period, then tick at old phase
        idle(3); wr(8'hC5); idle(PRE_N);
        check("R11", rd_data[6:0] !== 7'h45, rd_data[6:0], 7'h44);

        phase = "R7";
        wr(8'h48);
        check("R7", rd_data[7] === 1'b1, rd_data[7], 1);
        pulse_len("R7");

        phase = "R8";
        wr(8'hC8); idle(2); wr(8'h80);
        check("R8", rst_out_n === 1'b0, rst_out_n, 0);
        pulse_len("R4");

        phase = "R9";
        @(negedge clk); halt_req = 1; @(negedge clk); halt_req = 0;
        check("R9", rst_out_n === 1'b1, rst_out_n, 1);
        wr(8'hD0);
        @(negedge clk); halt_req = 1; @(negedge clk); halt_req = 0;
        check("R9", rst_out_n === 1'b0, rst_out_n, 0);
        idle(PW + 2);

        phase = "R10";
        do_reset(1);
        check("R10", rd_data === 8'hFF, rd_data, 8'hFF);
        wr(8'h20);
        pulse_len("R4");
        idle(1);
        check("R10", rd_data === 8'hFF, rd_data, 8'hFF);

        phase = "R4"; // random mix
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            wr_stb   = ($urandom % 6) == 0;
            wr_data  = 8'($urandom) | (($urandom % 8 != 0) ? 8'h40 : 8'h00);
            halt_req = ($urandom % 200) == 0;
            if (k == 1500) hw_en_cfg = 0;
        end
        @(negedge clk); wr_stb = 0; halt_req = 0;
        idle(2);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule